// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Timer

This block produces edge-aligned pulse-width modulation on several output pins. All channels share one up-counter and one period value. Each channel has its own compare value, which sets its duty, and its own control field, which enables the channel and picks its polarity. A power-of-two prescaler slows the rate at which the counter advances. Software programs the block through a single-cycle register port with address, write data, write enable and combinational read data.

While the counter runs, new period and compare values wait in shadow buffers. They move into the active registers on the wrap from the period value back to zero, so a period is never cut short or stretched part way through. While the counter is stopped, the same writes take effect in the cycle after the write. Channel control changes are never buffered. They reach the pin at once.

Top module: `pwm_shared_timer`

## Requirements
- R1: After reset the counter, the active period, every active compare value, the mode field and the prescale field are all zero, and every PWM output is low.
- R2: The clock-mode field is bits [1:0] of address 0, and the prescale field is bits [4:2]. Mode 00 holds the counter and prescaler still. Any nonzero mode advances the counter by one every 2^prescale input clocks.
- R3: The counter counts from 0 up to the active period value inclusive and then wraps to 0. One PWM period is therefore (period+1)·2^prescale input clocks.
- R4: While stopped, a write to the period register (address 2) or to a compare register takes effect in the next cycle, and reads return the new value. Writing the period does not change the counter.
- R5: While running, period and compare writes go to shadow buffers, and reads keep returning the active value. The buffers load into the active registers on the wrap. A write in the same cycle as the wrap is not part of that load: the active register takes the earlier buffer content, and the new value loads on the following wrap.
- R6: Any write to the counter register (address 1) sets the counter to zero, whatever the data. This write takes priority over a prescaled tick in the same cycle. Reading address 1 returns the live count.
- R7: With normal polarity an enabled channel is high while count < compare and low otherwise. A compare of 0 gives a constant low, and a compare above the period gives a constant high.
- R8: The channel control register n is at address 4+2n. Bit 5 is the edge-PWM mode bit, bit 4 a second mode bit that has no effect, and bits [3:2] are the edge/level select. A select of 10 gives normal polarity, 01 gives inverted polarity and 11 behaves as normal. A channel whose select is 00, or whose bit 5 is clear, drives 0.
- R9: A write to a channel control register changes that channel's output in the next cycle, whether or not the counter is running.
- R10: Channel compare register n is at address 5+2n. Control registers read back the stored bits in place, and addresses not listed here read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | AW (4) | Register address |
| wdata_i | input | CW (16) | Write data |
| rdata_o | output | CW (16) | Read data for addr_i, combinational |
| pwm_o | output | NCH (4) | One PWM output per channel |

## Verification
Two things can land in the same clock edge: a register write from software and the counter wrap that loads the shadow buffers. Both clashes are provoked. The bench polls the live count until it reads one below the period, then issues a period write that lands exactly on the wrap edge. The bench expects the old buffered period to be read back after that wrap, and the new one only after the next wrap. It also clears the counter in a cycle where a tick is due, and checks that the count reads zero and then one. Duty is judged by counting high samples over one full period and comparing against min(compare, period+1)·2^prescale, for every polarity and prescale combination in the sweep.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_COUNT  = 1;
  localparam int unsigned ADDR_PERIOD = 2;
  localparam int unsigned ADDR_CHBASE = 4;
  localparam int unsigned PS_LSB      = 2;
  // channel control bit positions
  localparam int unsigned CH_SEL_LSB  = 2;
  localparam int unsigned CH_MODEA    = 4;
  localparam int unsigned CH_MODEB    = 5;
  localparam logic [1:0]  SEL_OFF     = 2'b00;
  localparam logic [1:0]  SEL_INV     = 2'b01;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [PSW-1:0] ps_i,
  output logic           tick_o
);
  localparam int DIVW = (1 << PSW) - 1;

  logic [DIVW-1:0] div_q, div_d, lim;

  always_comb begin
    lim    = DIVW'((32'd1 << ps_i) - 32'd1);
    tick_o = run_i && (div_q == lim);
    if (!run_i || tick_o) div_d = '0;
    else                  div_d = div_q + DIVW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (div_q == '0));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic          mod_wr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] mod_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q, cnt_d, mod_q, mod_d, buf_q, buf_d;

  always_comb begin
    wrap_o = tick_i && (cnt_q == mod_q);
    if (clr_i)       cnt_d = '0;
    else if (wrap_o) cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + CW'(1);
    else             cnt_d = cnt_q;
    buf_d = mod_wr_i ? wdata_i : buf_q;
    if (mod_wr_i && !run_i) mod_d = wdata_i;
    else if (wrap_o)        mod_d = buf_q;
    else                    mod_d = mod_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mod_q <= '0;
      buf_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      mod_q <= mod_d;
      buf_q <= buf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign mod_o = mod_q;

  assert_stop_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_q));
  assert_wrap_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  assert_mod_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap_o) |=> $stable(mod_q));
  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          wrap_i,
  input  logic          ctl_wr_i,
  input  logic          cmp_wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic [CW-1:0] cnt_i,
  output logic [5:0]    ctl_o,
  output logic [CW-1:0] cmp_o,
  output logic          pwm_o
);
  logic [1:0]    sel_q, sel_d;
  logic          ma_q, ma_d, mb_q, mb_d;
  logic [CW-1:0] cmp_q, cmp_d, buf_q, buf_d;
  logic          active, raw;

  always_comb begin
    sel_d = ctl_wr_i ? wdata_i[CH_SEL_LSB +: 2] : sel_q;
    ma_d  = ctl_wr_i ? wdata_i[CH_MODEA]        : ma_q;
    mb_d  = ctl_wr_i ? wdata_i[CH_MODEB]        : mb_q;
    buf_d = cmp_wr_i ? wdata_i : buf_q;
    if (cmp_wr_i && !run_i) cmp_d = wdata_i;
    else if (wrap_i)        cmp_d = buf_q;
    else                    cmp_d = cmp_q;
    active = mb_q && (sel_q != SEL_OFF);
    raw    = cnt_i < cmp_q;
    pwm_o  = active && ((sel_q == SEL_INV) ? !raw : raw);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      ma_q  <= 1'b0;
      mb_q  <= 1'b0;
      cmp_q <= '0;
      buf_q <= '0;
    end else begin
      sel_q <= sel_d;
      ma_q  <= ma_d;
      mb_q  <= mb_d;
      cmp_q <= cmp_d;
      buf_q <= buf_d;
    end
  end

  assign ctl_o = {mb_q, ma_q, sel_q, 2'b00};
  assign cmp_o = cmp_q;

  assert_cmp_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap_i) |=> $stable(cmp_q));
  assert_off_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && !wdata_i[CH_MODEB]) |=> !pwm_o);
endmodule

// File: rtl/pwm_shared_timer.sv
module pwm_shared_timer
  import pwm_timer_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16,
  parameter int PSW = 3,
  parameter int AW  = $clog2(ADDR_CHBASE + 2 * NCH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] rdata_o,
  output logic [NCH-1:0] pwm_o
);
  logic [1:0]     mode_q, mode_d;
  logic [PSW-1:0] ps_q, ps_d;
  logic           run, tick, wrap, ctrl_wr, cnt_wr, mod_wr;
  logic [CW-1:0]  cnt, modv;
  logic [NCH-1:0] ctl_wr, cmp_wr;
  logic [5:0]     ctl_rd [NCH];
  logic [CW-1:0]  cmp_rd [NCH];

  assign ctrl_wr = we_i && (addr_i == AW'(ADDR_CTRL));
  assign cnt_wr  = we_i && (addr_i == AW'(ADDR_COUNT));
  assign mod_wr  = we_i && (addr_i == AW'(ADDR_PERIOD));
  assign run     = (mode_q != 2'b00);

  always_comb begin
    mode_d = ctrl_wr ? wdata_i[1:0]           : mode_q;
    ps_d   = ctrl_wr ? wdata_i[PS_LSB +: PSW] : ps_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ps_q   <= '0;
    end else begin
      mode_q <= mode_d;
      ps_q   <= ps_d;
    end
  end

  pwm_prescaler #(.PSW(PSW)) u_pre (
    .clk_i, .rst_ni, .run_i(run), .ps_i(ps_q), .tick_o(tick)
  );

  pwm_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .run_i(run), .tick_i(tick), .clr_i(cnt_wr),
    .mod_wr_i(mod_wr), .wdata_i, .cnt_o(cnt), .mod_o(modv), .wrap_o(wrap)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign ctl_wr[n] = we_i && (addr_i == AW'(ADDR_CHBASE + 2 * n));
    assign cmp_wr[n] = we_i && (addr_i == AW'(ADDR_CHBASE + 2 * n + 1));
    pwm_channel #(.CW(CW)) u_ch (
      .clk_i, .rst_ni, .run_i(run), .wrap_i(wrap),
      .ctl_wr_i(ctl_wr[n]), .cmp_wr_i(cmp_wr[n]), .wdata_i,
      .cnt_i(cnt), .ctl_o(ctl_rd[n]), .cmp_o(cmp_rd[n]), .pwm_o(pwm_o[n])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ADDR_CTRL))   rdata_o = CW'({ps_q, mode_q});
    if (addr_i == AW'(ADDR_COUNT))  rdata_o = cnt;
    if (addr_i == AW'(ADDR_PERIOD)) rdata_o = modv;
    for (int n = 0; n < NCH; n++) begin
      if (addr_i == AW'(ADDR_CHBASE + 2 * n))     rdata_o = CW'(ctl_rd[n]);
      if (addr_i == AW'(ADDR_CHBASE + 2 * n + 1)) rdata_o = cmp_rd[n];
    end
  end

  assert_stop_out_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && mod_wr) |=> (modv == $past(wdata_i)));
endmodule

// File: tb/pwm_shared_timer_tb_top.sv
module pwm_shared_timer_tb_top;
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int AW  = 4;

  logic          clk, rst_n, we;
  logic [AW-1:0] addr;
  logic [CW-1:0] wdata, rdata;
  logic [NCH-1:0] pwm;
  int tests = 0, fails = 0;
  bit done = 0;
  int hi_cnt [NCH];

  pwm_shared_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    addr = AW'(a); wdata = CW'(d); we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input int a, output int v);
    addr = AW'(a);
    #1 v = int'(rdata);
  endtask

  task automatic measure(input int n);
    for (int c = 0; c < NCH; c++) hi_cnt[c] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) if (pwm[c]) hi_cnt[c]++;
    end
  endtask

  initial begin
    int v, v2, n, e;
    we = 0; addr = '0; wdata = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 pwm", int'(pwm), 0);
    rd(1, v); check("R1 count", v, 0);
    rd(2, v); check("R1 period", v, 0);
    rd(0, v); check("R1 ctrl", v, 0);
    rd(5, v); check("R1 compare", v, 0);
    // R10 unmapped
    rd(3, v); check("R10 unmapped 3", v, 0);
    rd(12, v); check("R10 unmapped 12", v, 0);

    // Duty sweep (R3 R7 R8) over prescale, period and compare
    for (int ps = 0; ps < 3; ps++) begin
      for (int mi = 0; mi < 3; mi++) begin
        int m;
        m = (mi == 0) ? 2 : (mi == 1) ? 4 : 7;
        for (int c = 0; c <= m + 2; c++) begin
          wr(0, 0);
          wr(1, 0);
          wr(2, m);
          wr(4, 'h28); wr(5, c);
          wr(6, 'h24); wr(7, c);
          wr(8, 'h28); wr(9, m + 1);
          wr(10, 'h2C); wr(11, c);
          wr(0, (ps << 2) | 1);
          n = (m + 1) << ps;
          e = ((c < m + 1) ? c : m + 1) << ps;
          measure(n);
          check("R7 normal duty", hi_cnt[0], e);
          check("R8 inverted duty", hi_cnt[1], n - e);
          check("R7 full duty", hi_cnt[2], n);
          check("R8 reserved sel", hi_cnt[3], e);
        end
      end
    end

    // R10 readback of control fields
    rd(0, v); check("R10 ctrl readback", v, (2 << 2) | 1);
    rd(6, v); check("R10 chan ctl readback", v, 'h24);

    // R2 prescaled rate: ps=2, count after 40 clocks = 10
    wr(0, 0); wr(2, 1000); wr(1, 0);
    wr(0, (2 << 2) | 1);
    repeat (40) @(negedge clk);
    rd(1, v); check("R2 prescale rate", v, 10);
    // R2 stop holds
    wr(0, 0);
    rd(1, v);
    repeat (10) @(negedge clk);
    rd(1, v2); check("R2 stopped hold", v2, v);
    // R4 stopped write immediate, counter kept
    wr(2, 9);
    rd(2, v2); check("R4 period immediate", v2, 9);
    rd(1, v2); check("R4 counter kept", v2, v);
    wr(5, 3);
    rd(5, v2); check("R4 compare immediate", v2, 3);

    // R5 buffered while running
    wr(1, 0); wr(2, 7); wr(5, 7);
    wr(0, 1);
    repeat (3) @(negedge clk);
    wr(2, 3); wr(5, 2);
    rd(2, v); check("R5 period still active", v, 7);
    rd(5, v); check("R5 compare still active", v, 7);
    repeat (10) @(negedge clk);
    rd(2, v); check("R5 period loaded", v, 3);
    rd(5, v); check("R5 compare loaded", v, 2);
    // restore period 7 via wrap
    wr(2, 7);
    repeat (6) @(negedge clk);
    rd(2, v); check("R5 period restored", v, 7);

    // R5 collision: write lands on the wrap edge
    v = -1;
    for (int i = 0; i < 20 && v != 6; i++) begin
      rd(1, v);
      if (v != 6) @(negedge clk);
    end
    @(negedge clk);
    wr(2, 5);
    rd(2, v); check("R5 same-edge write not loaded", v, 7);
    repeat (10) @(negedge clk);
    rd(2, v); check("R5 same-edge write next wrap", v, 5);

    // R6 clear wins over tick (ps=0 ticks every clock)
    wr(1, 'h1234);
    rd(1, v); check("R6 clear wins", v, 0);
    @(negedge clk);
    rd(1, v); check("R6 count resumes", v, 1);

    // R9 immediate polarity change and R8 mode-bit gating, running
    wr(0, 0); wr(2, 7); wr(5, 20); wr(4, 'h28); wr(0, 1);
    @(negedge clk);
    check("R9 normal full high", int'(pwm[0]), 1);
    wr(4, 'h24);
    check("R9 inverted immediately", int'(pwm[0]), 0);
    wr(4, 'h28);
    check("R9 back to normal", int'(pwm[0]), 1);
    wr(4, 'h18);
    measure(8);
    check("R8 second mode bit only", hi_cnt[0], 0);
    wr(4, 'h20);
    measure(8);
    check("R8 select off", hi_cnt[0], 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule